// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital front end of a 14-bit serial-input converter. A host shifts a 16-bit command word in on a serial clock while chip select is held low. The word may be sent in one burst or as two 8-bit halves, as long as chip select stays low between them. When chip select returns high, the block acts on the word only if exactly 16 bits were clocked in. It holds two 14-bit registers. The staging register is loaded first. The conversion register drives the analog core and can be written directly or copied from the staging register. The block also drives a user logic pin and a sleep flag, and it sends the tail of its shift register out on a serial data pin, which serves daisy-chaining and readback.

All serial pins are oversampled on a fast system clock. Each pin passes through a synchronizer, and the serial clock's edges are detected in the system clock domain. A small state machine tracks each transfer. It sits in IDLE while chip select is high and moves to SHIFT when chip select falls. In SHIFT it counts rising serial clock edges. When chip select rises it goes to EXEC if the count is exactly 16, and to DROP otherwise. EXEC and DROP each last one cycle and then return to IDLE.

In EXEC the command is decoded and the registers are updated. In DROP nothing changes. The serial data output lags the input by 16 serial clocks in the rising-edge mode and by 16.5 serial clocks in the falling-edge mode, and the mode can be changed by a command.

Top module: `serdac_front`

## Requirements
- R1: After reset, dac_code is 0, upo is 0, sleep is 0, dout is 0 and the output mode is rising-edge (16-clock lag).
- R2: A word is executed only when cs_n rises after exactly 16 rising sclk edges. For any other count (0, 8, 15, 17 and so on), no register, pin or mode changes.
- R3: While cs_n is low, din is sampled on each sclk rising edge. The first bit sent becomes word bit 15. Bits 15:14 are the opcode, and bits 13:0 are the data, sent MSB first.
- R4: Opcode 00 loads the data into the staging register and leaves dac_code unchanged.
- R5: Opcode 01 loads the data into both the staging register and dac_code, and clears sleep.
- R6: Opcode 10 copies the staging register into dac_code and clears sleep. Its 14 data bits are ignored.
- R7: Opcode 11 with sub-code bits 13:11 = 010 drives upo low, and with sub-code 011 drives upo high.
- R8: With opcode 11, sub-code 100 selects the rising-edge mode and sub-code 101 selects the falling-edge mode. Sub-codes 000, 001 and 110 change nothing.
- R9: Opcode 11 with sub-code 111 sets sleep only while pdl is high. While pdl is low the command has no effect.
- R10: In rising-edge mode, dout changes only on sclk rising edges and shows the bit that entered 16 rising edges earlier. The shift register keeps its contents across frames and starts at zero.
- R11: In falling-edge mode, dout changes on sclk falling edges. After a rise it still shows the bit from 17 rises back, and after the following fall it shows the bit from 16 rises back, which is a lag of 16.5 clocks.
- R12: While sleep is set, dout holds the value it had when sleep was entered, even while bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in |
| pdl | input | 1 | Sleep enable; sleep command is honoured only while high |
| dout | output | 1 | Serial data out (shift register tail) |
| upo | output | 1 | User-programmable logic output |
| sleep | output | 1 | Converter sleep flag |
| dac_code | output | 14 | Conversion register contents |

## Verification
The hardest behaviour to reach is the half-cycle difference between the two output modes. At the instant after a falling edge, both modes show the same bit, so a bench that samples only there cannot tell them apart. The stimulus therefore samples dout in both serial clock phases, after each rise and after each fall. It compares the result against a history of every bit ever shifted, including bits from earlier frames. The sleep hold is reached by entering sleep and then clocking a full harmless frame, which checks that dout stays frozen while the shift register moves underneath.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef enum logic [1:0] {
        FE_IDLE,
        FE_SHIFT,
        FE_EXEC,
        FE_DROP
    } fe_state_e;

    typedef enum logic [1:0] {
        OP_LOAD_IN   = 2'b00,
        OP_LOAD_BOTH = 2'b01,
        OP_PROMOTE   = 2'b10,
        OP_EXT       = 2'b11
    } op_e;

    localparam int SUB_W = 3;

    localparam logic [SUB_W-1:0] SUB_UPO_LO = 3'b010;
    localparam logic [SUB_W-1:0] SUB_UPO_HI = 3'b011;
    localparam logic [SUB_W-1:0] SUB_EDGE_R = 3'b100;
    localparam logic [SUB_W-1:0] SUB_EDGE_F = 3'b101;
    localparam logic [SUB_W-1:0] SUB_SLEEP  = 3'b111;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d};
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              mode_late,
    input  logic              sleep,
    output logic [WORD_W-1:0] word,
    output logic              dout
);
    logic [WORD_W-1:0] sr_q;
    logic              rise_stage_q;
    logic              fall_stage_q;
    logic              hold_q;
    logic              live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q         <= '0;
            rise_stage_q <= 1'b0;
            fall_stage_q <= 1'b0;
        end else begin
            if (shift_en && rise) begin
                sr_q         <= {sr_q[WORD_W-2:0], din};
                rise_stage_q <= sr_q[WORD_W-1];
            end
            if (shift_en && fall) begin
                fall_stage_q <= rise_stage_q;
            end
        end
    end

    assign live = mode_late ? fall_stage_q : rise_stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (!sleep) begin
            hold_q <= live;
        end
    end

    assign dout = sleep ? hold_q : live;
    assign word = sr_q;

    // R3
    sr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));
    // R10
    rise_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && rise) |=> $stable(rise_stage_q));
    // R11
    fall_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && fall) |=> $stable(fall_stage_q));
    // R12
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |-> $stable(dout));
endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
    import dacif_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DATA_W = WORD_W - 2,
    parameter int CNT_W  = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise,
    input  logic [WORD_W-1:0] word,
    input  logic              pdl,
    output logic [DATA_W-1:0] dac_code,
    output logic              sleep,
    output logic              upo,
    output logic              mode_late
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    fe_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] stage_q, dac_q;
    logic              upo_q, sleep_q, mode_q;
    op_e               op;
    logic [SUB_W-1:0]  sub;
    logic [DATA_W-1:0] data;

    assign op   = op_e'(word[WORD_W-1 -: 2]);
    assign data = word[DATA_W-1:0];
    assign sub  = word[DATA_W-1 -: SUB_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FE_IDLE:  if (cs_act) state_d = FE_SHIFT;
            FE_SHIFT: if (!cs_act) state_d = (cnt_q == CNT_FULL) ? FE_EXEC : FE_DROP;
            FE_EXEC:  state_d = FE_IDLE;
            FE_DROP:  state_d = FE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                FE_IDLE:  cnt_q <= (cs_act && rise) ? CNT_W'(1) : '0;
                FE_SHIFT: if (cs_act && rise && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
                FE_EXEC,
                FE_DROP:  cnt_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            dac_q   <= '0;
            upo_q   <= 1'b0;
            sleep_q <= 1'b0;
            mode_q  <= 1'b0;
        end else if (state_q == FE_EXEC) begin
            unique case (op)
                OP_LOAD_IN: stage_q <= data;
                OP_LOAD_BOTH: begin
                    stage_q <= data;
                    dac_q   <= data;
                    sleep_q <= 1'b0;
                end
                OP_PROMOTE: begin
                    dac_q   <= stage_q;
                    sleep_q <= 1'b0;
                end
                OP_EXT: begin
                    case (sub)
                        SUB_UPO_LO: upo_q  <= 1'b0;
                        SUB_UPO_HI: upo_q  <= 1'b1;
                        SUB_EDGE_R: mode_q <= 1'b0;
                        SUB_EDGE_F: mode_q <= 1'b1;
                        SUB_SLEEP:  if (pdl) sleep_q <= 1'b1;
                        default:    ;
                    endcase
                end
            endcase
        end
    end

    assign dac_code  = dac_q;
    assign sleep     = sleep_q;
    assign upo       = upo_q;
    assign mode_late = mode_q;

    // R2
    frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FE_EXEC) |=> ($stable(dac_q) && $stable(stage_q) &&
                                  $stable(upo_q) && $stable(mode_q) && $stable(sleep_q)));
    // R9
    pdl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FE_EXEC && op == OP_EXT && sub == SUB_SLEEP && !pdl && !sleep_q)
            |=> !sleep_q);
    // R5
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_q) |-> $past(state_q == FE_EXEC));
    // R2
    exec_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == FE_EXEC && state_q == FE_SHIFT) |-> (cnt_q == CNT_FULL));
endmodule

// File: rtl/serdac_front.sv
module serdac_front #(
    parameter int WORD_W      = 16,
    parameter int DATA_W      = WORD_W - 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              pdl,
    output logic              dout,
    output logic              upo,
    output logic              sleep,
    output logic [DATA_W-1:0] dac_code
);
    localparam int PIN_W = 4;

    logic [PIN_W-1:0]  pins_s;
    logic              sclk_s, csn_s, din_s, pdl_s;
    logic              sclk_p;
    logic              rise, fall;
    logic              mode_late;
    logic [WORD_W-1:0] word;

    dacif_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, cs_n, din, pdl}),
        .q    (pins_s)
    );

    assign {sclk_s, csn_s, din_s, pdl_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_p <= 1'b0;
        else        sclk_p <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_p;
    assign fall = ~sclk_s & sclk_p;

    dacif_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (~csn_s),
        .rise     (rise),
        .fall     (fall),
        .din      (din_s),
        .mode_late(mode_late),
        .sleep    (sleep),
        .word     (word),
        .dout     (dout)
    );

    dacif_ctrl #(
        .WORD_W(WORD_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (~csn_s),
        .rise     (rise),
        .word     (word),
        .pdl      (pdl_s),
        .dac_code (dac_code),
        .sleep    (sleep),
        .upo      (upo),
        .mode_late(mode_late)
    );
endmodule

// File: tb/tb_serdac_front.sv
module tb_serdac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        pdl = 1'b0;
    logic        dout, upo, sleep;
    logic [13:0] dac_code;

    int          n_chk = 0;
    int          n_err = 0;
    logic [63:0] hist = '0;
    logic        late = 1'b0;
    logic        hold_v = 1'b0;
    logic [13:0] stage_m = '0;
    logic [13:0] dac_m = '0;

    always #4 clk = ~clk;

    serdac_front dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .pdl(pdl),
        .dout(dout), .upo(upo), .sleep(sleep), .dac_code(dac_code)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [13:0] d);
        return {16'h0, op, d};
    endfunction

    function automatic logic [31:0] ext(input logic [2:0] s);
        return {16'h0, 2'b11, s, 11'h5A5};
    endfunction

    // dchk: 0 none, 1 lag checks, 2 sleep hold checks
    task automatic frame(input logic [31:0] w, input int n, input int dchk);
        cs_n = 1'b0;
        tick(6);
        for (int i = 0; i < n; i++) begin
            din = w[n-1-i];
            tick(6);
            sclk = 1'b1;
            hist = {hist[62:0], din};
            tick(6);
            if (dchk == 1) chk(late ? "R11 after rise" : "R10 after rise", 32'(dout),
                               32'(late ? hist[17] : hist[16]));
            if (dchk == 2) chk("R12 rise", 32'(dout), 32'(hold_v));
            sclk = 1'b0;
            tick(6);
            if (dchk == 1) chk(late ? "R11 after fall" : "R10 after fall", 32'(dout),
                               32'(hist[16]));
            if (dchk == 2) chk("R12 fall", 32'(dout), 32'(hold_v));
        end
        cs_n = 1'b1;
        tick(12);
    endtask

    initial begin
        tick(200000 - 10);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 dac", 32'(dac_code), 32'h0);
        chk("R1 upo", 32'(upo), 32'h0);
        chk("R1 sleep", 32'(sleep), 32'h0);
        chk("R1 dout", 32'(dout), 32'h0);

        // R3 R5 walking ones and patterns through opcode 01
        for (int i = 0; i < 14; i++) begin
            frame(mk(2'b01, 14'(1 << i)), 16, 0);
            chk("R3 R5 walk", 32'(dac_code), 32'(1 << i));
        end
        foreach (stage_m[k]) begin end
        begin
            logic [13:0] pats [4] = '{14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555};
            for (int i = 0; i < 4; i++) begin
                frame(mk(2'b01, pats[i]), 16, 0);
                chk("R5 pattern", 32'(dac_code), 32'(pats[i]));
            end
            dac_m = pats[3];
            stage_m = pats[3];
        end

        // R4 staging only, then R6 promote with junk data
        for (int i = 0; i < 4; i++) begin
            logic [13:0] v;
            v = 14'(14'h0123 * (i + 3) + i);
            frame(mk(2'b00, v), 16, 0);
            chk("R4 dac unchanged", 32'(dac_code), 32'(dac_m));
            frame(mk(2'b10, ~v), 16, 0);
            dac_m = v;
            chk("R6 promote", 32'(dac_code), 32'(dac_m));
        end

        // R2 aborted frames
        frame(mk(2'b01, 14'h0F0F), 15, 0);
        chk("R2 15 bits", 32'(dac_code), 32'(dac_m));
        frame({mk(2'b01, 14'h0F0F), 1'b0} , 17, 0);
        chk("R2 17 bits", 32'(dac_code), 32'(dac_m));
        frame(32'h41, 8, 0);
        chk("R2 8 bits", 32'(dac_code), 32'(dac_m));
        frame(32'h0, 0, 0);
        chk("R2 0 bits", 32'(dac_code), 32'(dac_m));
        frame({ext(3'b011), 1'b1}, 17, 0);
        chk("R2 ext 17 bits upo", 32'(upo), 32'h0);

        // R7 upo, R8 no-op sub-codes
        frame(ext(3'b011), 16, 0);
        chk("R7 upo high", 32'(upo), 32'h1);
        frame(ext(3'b000), 16, 0);
        chk("R8 sub 000", 32'(upo), 32'h1);
        frame(ext(3'b001), 16, 0);
        chk("R8 sub 001", 32'(upo), 32'h1);
        frame(ext(3'b110), 16, 0);
        chk("R8 sub 110", 32'(upo), 32'h1);
        chk("R8 dac kept", 32'(dac_code), 32'(dac_m));
        frame(ext(3'b010), 16, 0);
        chk("R7 upo low", 32'(upo), 32'h0);

        // R10 rising-edge mode lag
        frame(mk(2'b00, 14'h2B3C), 16, 1);
        frame(mk(2'b00, 14'h1C47), 16, 1);
        // R11 falling-edge mode lag
        frame(ext(3'b101), 16, 0);
        late = 1'b1;
        frame(mk(2'b00, 14'h35A9), 16, 1);
        frame(mk(2'b00, 14'h0E61), 16, 1);
        // R8 back to rising-edge mode
        frame(ext(3'b100), 16, 0);
        late = 1'b0;
        frame(mk(2'b00, 14'h3D02), 16, 1);
        stage_m = 14'h3D02;

        // R9 pdl gating
        pdl = 1'b0;
        tick(4);
        frame(ext(3'b111), 16, 0);
        chk("R9 pdl low ignored", 32'(sleep), 32'h0);
        pdl = 1'b1;
        tick(4);
        frame(ext(3'b111), 16, 0);
        chk("R9 pdl high sleeps", 32'(sleep), 32'h1);
        hold_v = dout;
        // R12 hold while shifting a staging-only frame
        frame(mk(2'b00, {14{~hold_v}} ^ 14'h0155), 16, 2);
        chk("R12 still asleep", 32'(sleep), 32'h1);
        chk("R4 dac while asleep", 32'(dac_code), 32'(dac_m));
        // R6 promote wakes
        frame(mk(2'b10, 14'h0), 16, 0);
        dac_m = {14{~hold_v}} ^ 14'h0155;
        chk("R6 wake", 32'(sleep), 32'h0);
        chk("R6 promoted", 32'(dac_code), 32'(dac_m));
        chk("R10 live after wake", 32'(dout), 32'(hist[16]));
        // R5 wake via opcode 01
        frame(ext(3'b111), 16, 0);
        chk("R9 sleep again", 32'(sleep), 32'h1);
        frame(mk(2'b01, 14'h2468), 16, 0);
        chk("R5 wake", 32'(sleep), 32'h0);
        chk("R5 value", 32'(dac_code), 32'h2468);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule